// File: doc/BRIEF.md
# Spill-Triggered Hit-Sampling Event Buffer

This block captures binary discriminator outputs from a group of detector channels. Each channel is sampled every 5 ns. The logic core runs at 100 MHz, so each core cycle brings two samples per channel: an early sample on `hit_early` and a late sample on `hit_late`, taken by a two-phase capture stage ahead of the block. A start pulse opens a recording window of fixed length, with no dead time. For every 5 ns slice, the block stores a leading-edge mask: a channel is marked in a slice only when its level goes from 0 to 1 into that slice.

When the window closes, the buffer is held until a separate readout command arrives. The readout then walks the buffer in ascending slice order and drops every slice that has no hits. The output is a framed serial word stream. It opens with a header that carries the spill number, then gives one tagged word per surviving slice, and ends with a trailer that holds the count of data words. A spill counter counts accepted start pulses and has its own clear input.

The control state machine has four states. It moves IDLE to RECORD on an accepted start. It moves RECORD to ARMED when the last slot pair has been written. It moves ARMED to READOUT on a readout command. It moves READOUT back to IDLE when the last trailer bit has left. The readout sequencer has seven states: idle, head, fetch, even, odd, tail and drain. It goes from head to fetch. It then loops fetch, even, odd, and returns to fetch, once per stored slot pair. After the last pair it moves through tail and drain and back to idle. The serializer alternates between idle and shift.

Top module: `spill_hit_buffer`

## Requirements
- R1: A channel is marked in the early slice of a pair when `hit_early` is 1 and that channel's `hit_late` was 0 in the previous core cycle. It is marked in the late slice when `hit_late` is 1 and `hit_early` in the same cycle is 0. A level held high marks only its first slice.
- R2: The first core cycle after an accepted start records slot pair 0. Each following cycle records the next pair, for PAIRS = 2^(SLOT_AW-1) cycles. Pair k holds slot 2k (early sample) and slot 2k+1 (late sample).
- R3: `busy` is high from the cycle after an accepted start until the last trailer bit has been sent. A start pulse while `busy` is high is ignored: the window is not restarted and the spill counter does not advance.
- R4: A readout command is acted on only in the ARMED state. A command while idle or while recording has no effect: no word is sent and, when idle, `busy` stays low.
- R5: Readout sends one data word per slice with a non-zero mask, in ascending slot order, and no word for an empty slice. A window with no hits sends only a header and a trailer.
- R6: Words are WORD_W = 2+SLOT_AW+NCH bits, with a 2-bit tag in the top bits. A data word is {2'b01, slot address, hit mask}. The header is {2'b10, spill number zero-extended}. The trailer is {2'b11, data-word count zero-extended}.
- R7: The spill number of a window is the number of starts accepted since the last spill clear. A clear without a start empties the counter. A clear in the same cycle as an accepted start gives that window number 0, and the next window number 1.
- R8: Each word is sent MSB first. `ser_frame` is high for exactly WORD_W consecutive cycles per word and low for at least one cycle between words. No frame appears outside READOUT.
- R9: After reset, `busy`, `ser_frame` and `ser_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_early | input | NCH | Early 5 ns sample of each discriminator |
| hit_late | input | NCH | Late 5 ns sample of each discriminator |
| start_pulse | input | 1 | Opens a recording window (T0) |
| readout_go | input | 1 | Starts readout of an armed buffer |
| spill_clr | input | 1 | Clears the spill counter |
| busy | output | 1 | Window recording, armed or being read out |
| ser_data | output | 1 | Serial word stream, MSB first |
| ser_frame | output | 1 | High while a word is on `ser_data` |

## Verification
`busy` is due one core cycle after the edge that accepts a start, and the bench reads it at the next falling edge. The pair driven at the k-th falling edge after the start is written at the rising edge that follows it. The expected slot addresses come from that count. The serial results have no fixed latency because zero suppression changes the scan time. The bench therefore decodes the stream at falling edges while `ser_frame` is high, and compares whole words in order once `busy` drops. Ignored-command checks wait a set number of cycles and then confirm that no frame has appeared and that `busy` still holds its value.

// File: rtl/shb_pkg.sv
package shb_pkg;

    typedef enum logic [1:0] {
        CT_IDLE    = 2'd0,
        CT_RECORD  = 2'd1,
        CT_ARMED   = 2'd2,
        CT_READOUT = 2'd3
    } ctrl_state_t;

    typedef enum logic [2:0] {
        RD_IDLE  = 3'd0,
        RD_HEAD  = 3'd1,
        RD_FETCH = 3'd2,
        RD_EVEN  = 3'd3,
        RD_ODD   = 3'd4,
        RD_TAIL  = 3'd5,
        RD_DRAIN = 3'd6
    } rd_state_t;

    typedef enum logic {
        SR_IDLE  = 1'b0,
        SR_SHIFT = 1'b1
    } ser_state_t;

    localparam logic [1:0] TAG_DATA = 2'b01;
    localparam logic [1:0] TAG_HEAD = 2'b10;
    localparam logic [1:0] TAG_TAIL = 2'b11;

endpackage

// File: rtl/shb_edge_capture.sv
module shb_edge_capture #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_early,
    input  logic [NCH-1:0] hit_late,
    output logic [NCH-1:0] edge_early,
    output logic [NCH-1:0] edge_late
);
    // level of the late sample one core cycle back
    logic [NCH-1:0] prev_late;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_late <= '0;
        else        prev_late <= hit_late;
    end

    always_comb begin
        edge_early = hit_early & ~prev_late;
        edge_late  = hit_late  & ~hit_early;
    end
endmodule

// File: rtl/shb_slot_mem.sv
module shb_slot_mem #(
    parameter int DW = 32,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end
endmodule

// File: rtl/shb_reader.sv
module shb_reader
    import shb_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int SLOT_AW = 10,
    parameter int SPILL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  kick,
    input  logic [SPILL_W-1:0]    spill_tag,
    output logic [SLOT_AW-2:0]    rd_addr,
    input  logic [2*NCH-1:0]      rd_data,
    output logic [2+SLOT_AW+NCH-1:0] word,
    output logic                  word_valid,
    input  logic                  word_ready,
    output logic                  done
);
    localparam int PAIR_AW = SLOT_AW - 1;
    localparam int PAY_W   = SLOT_AW + NCH;
    localparam int CNT_W   = SLOT_AW + 1;

    rd_state_t          st, nxt;
    logic [PAIR_AW-1:0] ent;
    logic [CNT_W-1:0]   cnt;
    logic               even_nz, odd_nz, last_ent, data_take;

    assign even_nz  = |rd_data[NCH-1:0];
    assign odd_nz   = |rd_data[2*NCH-1:NCH];
    assign last_ent = (ent == '1);
    assign rd_addr  = ent;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RD_IDLE:  if (kick) nxt = RD_HEAD;
            RD_HEAD:  if (word_ready) nxt = RD_FETCH;
            RD_FETCH: nxt = RD_EVEN;
            RD_EVEN:  if (!even_nz || word_ready) nxt = RD_ODD;
            RD_ODD: begin
                if (!odd_nz || word_ready) nxt = last_ent ? RD_TAIL : RD_FETCH;
            end
            RD_TAIL:  if (word_ready) nxt = RD_DRAIN;
            RD_DRAIN: if (word_ready) nxt = RD_IDLE;
            default:  nxt = RD_IDLE;
        endcase
    end

    always_comb begin
        word       = '0;
        word_valid = 1'b0;
        done       = 1'b0;
        unique case (st)
            RD_HEAD: begin
                word       = {TAG_HEAD, PAY_W'(spill_tag)};
                word_valid = 1'b1;
            end
            RD_EVEN: begin
                word       = {TAG_DATA, ent, 1'b0, rd_data[NCH-1:0]};
                word_valid = even_nz;
            end
            RD_ODD: begin
                word       = {TAG_DATA, ent, 1'b1, rd_data[2*NCH-1:NCH]};
                word_valid = odd_nz;
            end
            RD_TAIL: begin
                word       = {TAG_TAIL, PAY_W'(cnt)};
                word_valid = 1'b1;
            end
            RD_DRAIN: done = word_ready;
            default: ;
        endcase
    end

    assign data_take = word_valid && word_ready && (st == RD_EVEN || st == RD_ODD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent <= '0;
            cnt <= '0;
        end else if (st == RD_IDLE && kick) begin
            ent <= '0;
            cnt <= '0;
        end else begin
            if (data_take) cnt <= cnt + 1'b1;
            if (st == RD_ODD && (!odd_nz || word_ready) && !last_ent) ent <= ent + 1'b1;
        end
    end
endmodule

// File: rtl/shb_serializer.sv
module shb_serializer
    import shb_pkg::*;
#(
    parameter int WORD_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              ser_data,
    output logic              ser_frame
);
    localparam int BC_W = $clog2(WORD_W);

    ser_state_t        st, nxt;
    logic [WORD_W-1:0] shreg;
    logic [BC_W-1:0]   bits_left;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SR_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            SR_IDLE:  if (word_valid) nxt = SR_SHIFT;
            SR_SHIFT: if (bits_left == '0) nxt = SR_IDLE;
            default:  nxt = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (st == SR_IDLE && word_valid) begin
            shreg     <= word;
            bits_left <= BC_W'(WORD_W - 1);
        end else if (st == SR_SHIFT) begin
            shreg     <= shreg << 1;
            bits_left <= bits_left - 1'b1;
        end
    end

    always_comb begin
        word_ready = (st == SR_IDLE);
        ser_frame  = (st == SR_SHIFT);
        ser_data   = (st == SR_SHIFT) ? shreg[WORD_W-1] : 1'b0;
    end
endmodule

// File: rtl/spill_hit_buffer.sv
module spill_hit_buffer
    import shb_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int SLOT_AW = 10,
    parameter int SPILL_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_early,
    input  logic [NCH-1:0] hit_late,
    input  logic           start_pulse,
    input  logic           readout_go,
    input  logic           spill_clr,
    output logic           busy,
    output logic           ser_data,
    output logic           ser_frame
);
    localparam int PAIR_AW = SLOT_AW - 1;
    localparam int PAIRS   = 2 ** PAIR_AW;
    localparam int WORD_W  = 2 + SLOT_AW + NCH;

    ctrl_state_t        ctrl_st, ctrl_nxt;
    logic [PAIR_AW-1:0] wptr, rd_addr;
    logic [NCH-1:0]     edge_early, edge_late;
    logic [2*NCH-1:0]   rd_data;
    logic [SPILL_W-1:0] spill_cnt, spill_tag, spill_base;
    logic [WORD_W-1:0]  word;
    logic               word_valid, word_ready, rd_done;
    logic               accept_start, rec_we, rd_kick, last_pair;

    // ---------------- control state machine ----------------
    assign accept_start = (ctrl_st == CT_IDLE) && start_pulse;
    assign last_pair    = (wptr == PAIR_AW'(PAIRS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_st <= CT_IDLE;
        else        ctrl_st <= ctrl_nxt;
    end

    always_comb begin
        ctrl_nxt = ctrl_st;
        unique case (ctrl_st)
            CT_IDLE:    if (start_pulse) ctrl_nxt = CT_RECORD;
            CT_RECORD:  if (last_pair) ctrl_nxt = CT_ARMED;
            CT_ARMED:   if (readout_go) ctrl_nxt = CT_READOUT;
            CT_READOUT: if (rd_done) ctrl_nxt = CT_IDLE;
            default:    ctrl_nxt = CT_IDLE;
        endcase
    end

    always_comb begin
        busy    = (ctrl_st != CT_IDLE);
        rec_we  = (ctrl_st == CT_RECORD);
        rd_kick = (ctrl_st == CT_ARMED) && readout_go;
    end

    // ---------------- write pointer ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)            wptr <= '0;
        else if (accept_start) wptr <= '0;
        else if (rec_we)       wptr <= wptr + 1'b1;
    end

    // ---------------- spill counter ----------------
    assign spill_base = spill_clr ? '0 : spill_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spill_cnt <= '0;
            spill_tag <= '0;
        end else if (accept_start) begin
            spill_tag <= spill_base;
            spill_cnt <= spill_base + 1'b1;
        end else begin
            spill_cnt <= spill_base;
        end
    end

    // ---------------- datapath ----------------
    shb_edge_capture #(.NCH(NCH)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_early  (hit_early),
        .hit_late   (hit_late),
        .edge_early (edge_early),
        .edge_late  (edge_late)
    );

    shb_slot_mem #(.DW(2*NCH), .AW(PAIR_AW)) u_mem (
        .clk   (clk),
        .we    (rec_we),
        .waddr (wptr),
        .wdata ({edge_late, edge_early}),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    shb_reader #(.NCH(NCH), .SLOT_AW(SLOT_AW), .SPILL_W(SPILL_W)) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick       (rd_kick),
        .spill_tag  (spill_tag),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .word       (word),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .done       (rd_done)
    );

    shb_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (word),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .ser_data   (ser_data),
        .ser_frame  (ser_frame)
    );
endmodule

// File: rtl/shb_checker.sv
module shb_checker #(
    parameter int WORD_W  = 28,
    parameter int PAIRS   = 512,
    parameter int SPILL_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_pulse,
    input logic               readout_go,
    input logic               spill_clr,
    input logic               busy,
    input logic               ser_frame,
    input logic [1:0]         ctrl_state,
    input logic [SPILL_W-1:0] spill_cnt
);
    logic        recording;
    logic [31:0] frame_run, rec_run;

    assign recording = (ctrl_state == 2'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_run <= '0;
            rec_run   <= '0;
        end else begin
            frame_run <= ser_frame ? frame_run + 1 : '0;
            rec_run   <= recording ? rec_run + 1 : '0;
        end
    end

    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recording) |-> rec_run == 32'(PAIRS)); // R2
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_pulse) |=> busy); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_pulse && !spill_clr) |=> $stable(spill_cnt)); // R3
    AST_GO_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == 2'd0 && readout_go && !start_pulse) |=> !busy); // R4
    AST_SPILL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_clr && !start_pulse) |=> spill_cnt == '0); // R7
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_frame) |-> frame_run == 32'(WORD_W)); // R8
    AST_FRAME_ONLY_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state != 2'd3) |-> !ser_frame); // R8
endmodule

bind spill_hit_buffer shb_checker #(
    .WORD_W  (WORD_W),
    .PAIRS   (PAIRS),
    .SPILL_W (SPILL_W)
) u_shb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .readout_go  (readout_go),
    .spill_clr   (spill_clr),
    .busy        (busy),
    .ser_frame   (ser_frame),
    .ctrl_state  (ctrl_st),
    .spill_cnt   (spill_cnt)
);

// File: tb/spill_hit_buffer_bench.sv
`timescale 1ns/1ps
module spill_hit_buffer_bench;
    localparam int NCH     = 16;
    localparam int SLOT_AW = 10;
    localparam int SPILL_W = 16;
    localparam int PAIRS   = 2 ** (SLOT_AW - 1);
    localparam int WORD_W  = 2 + SLOT_AW + NCH;
    localparam int PAY_W   = SLOT_AW + NCH;
    localparam int NV      = 10;

    // vector: {scenario, pair index, early mask, late mask}
    localparam logic [42:0] VEC [NV] = '{
        {2'd0, 9'd0,   16'h0001, 16'h0001},
        {2'd0, 9'd5,   16'h0000, 16'h8000},
        {2'd0, 9'd6,   16'h8000, 16'h0000},
        {2'd1, 9'd3,   16'h00F0, 16'h0F0F},
        {2'd1, 9'd4,   16'h0F0F, 16'h0000},
        {2'd1, 9'd510, 16'h1234, 16'h1234},
        {2'd1, 9'd511, 16'h0000, 16'hFFFF},
        {2'd2, 9'd100, 16'hAAAA, 16'h5555},
        {2'd2, 9'd101, 16'h5555, 16'hAAAA},
        {2'd2, 9'd300, 16'h0000, 16'h0400}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] hit_early = '0, hit_late = '0;
    logic           start_pulse = 1'b0, readout_go = 1'b0, spill_clr = 1'b0;
    logic           busy, ser_data, ser_frame;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    logic [NCH-1:0]    st_e [PAIRS];
    logic [NCH-1:0]    st_l [PAIRS];
    logic [WORD_W-1:0] rx_w [512];
    int                rx_len [512];
    int                rx_n = 0;
    int                cur_bits = 0;
    logic [WORD_W-1:0] cur_w = '0;
    logic [WORD_W-1:0] exp_w [64];
    int                exp_n;

    always #5 clk = ~clk;

    spill_hit_buffer #(.NCH(NCH), .SLOT_AW(SLOT_AW), .SPILL_W(SPILL_W)) u_spill_hit_buffer (
        .clk(clk), .rst_n(rst_n), .hit_early(hit_early), .hit_late(hit_late),
        .start_pulse(start_pulse), .readout_go(readout_go), .spill_clr(spill_clr),
        .busy(busy), .ser_data(ser_data), .ser_frame(ser_frame)
    );

    // serial decoder, sampled at falling edges
    always @(negedge clk) begin
        if (ser_frame) begin
            cur_w    = {cur_w[WORD_W-2:0], ser_data};
            cur_bits = cur_bits + 1;
        end else if (cur_bits > 0) begin
            if (rx_n < 512) begin
                rx_w[rx_n]   = cur_w;
                rx_len[rx_n] = cur_bits;
                rx_n         = rx_n + 1;
            end
            cur_bits = 0;
            cur_w    = '0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clear_stim();
        for (int k = 0; k < PAIRS; k++) begin
            st_e[k] = '0;
            st_l[k] = '0;
        end
    endtask

    task automatic build_expected(input int spill);
        logic [NCH-1:0] prev, ea, eb;
        int cnt;
        prev  = '0;
        cnt   = 0;
        exp_n = 0;
        exp_w[exp_n++] = {2'b10, PAY_W'(spill)};
        for (int k = 0; k < PAIRS; k++) begin
            ea = st_e[k] & ~prev;
            eb = st_l[k] & ~st_e[k];
            if (ea != '0 && exp_n < 63) begin
                exp_w[exp_n++] = {2'b01, SLOT_AW'(2*k), ea};
                cnt++;
            end
            if (eb != '0 && exp_n < 63) begin
                exp_w[exp_n++] = {2'b01, SLOT_AW'(2*k+1), eb};
                cnt++;
            end
            prev = st_l[k];
        end
        exp_w[exp_n++] = {2'b11, PAY_W'(cnt)};
    endtask

    // records one window from st_e/st_l, reads it out, compares the stream
    task automatic run_window(input int spill, input int start_at, input int go_at, input bit clr_with_start);
        int base, waited;
        bit lens_ok;
        base = rx_n;
        build_expected(spill);
        @(negedge clk);
        hit_early = '0; hit_late = '0;
        start_pulse = 1'b1;
        spill_clr = clr_with_start;
        for (int k = 0; k < PAIRS; k++) begin
            @(negedge clk);
            if (k == 0) chk(busy == 1'b1, "R3 busy after accepted start", 64'(busy), 64'd1);
            start_pulse = (k == start_at);
            readout_go  = (k == go_at);
            spill_clr   = 1'b0;
            hit_early   = st_e[k];
            hit_late    = st_l[k];
        end
        @(negedge clk);
        hit_early = '0; hit_late = '0; start_pulse = 1'b0; readout_go = 1'b0;
        repeat (30) @(negedge clk);
        chk(rx_n == base, "R4 no words before readout command", 64'(rx_n - base), 64'd0);
        chk(busy == 1'b1, "R4 armed buffer stays busy", 64'(busy), 64'd1);
        readout_go = 1'b1;
        @(negedge clk);
        readout_go = 1'b0;
        waited = 0;
        while (busy && waited < 8000) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R3 busy low after trailer", 64'(busy), 64'd0);
        chk(rx_n - base == exp_n, "R5 word count", 64'(rx_n - base), 64'(exp_n));
        lens_ok = 1'b1;
        for (int i = 0; i < exp_n && base + i < rx_n; i++) begin
            if (rx_len[base+i] != WORD_W) lens_ok = 1'b0;
            if (i == 0)
                chk(rx_w[base+i] == exp_w[i], "R6/R7 header spill", 64'(rx_w[base+i]), 64'(exp_w[i]));
            else if (i == exp_n - 1)
                chk(rx_w[base+i] == exp_w[i], "R6 trailer count", 64'(rx_w[base+i]), 64'(exp_w[i]));
            else
                chk(rx_w[base+i] == exp_w[i], "R1/R2/R5 data word", 64'(rx_w[base+i]), 64'(exp_w[i]));
        end
        chk(lens_ok, "R8 frame length", 64'(lens_ok), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0, "R9 busy after reset", 64'(busy), 64'd0);
        chk(ser_frame == 1'b0, "R9 frame after reset", 64'(ser_frame), 64'd0);
        chk(ser_data == 1'b0, "R9 data after reset", 64'(ser_data), 64'd0);

        // R4 readout command while idle is ignored
        base = rx_n;
        readout_go = 1'b1;
        @(negedge clk);
        readout_go = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R4 idle command leaves busy low", 64'(busy), 64'd0);
        chk(rx_n == base, "R4 idle command sends nothing", 64'(rx_n - base), 64'd0);

        // table-driven windows, spill numbers 0,1,2
        for (int s = 0; s < 3; s++) begin
            clear_stim();
            for (int v = 0; v < NV; v++) begin
                if (int'(VEC[v][42:41]) == s) begin
                    st_e[VEC[v][40:32]] = VEC[v][31:16];
                    st_l[VEC[v][40:32]] = VEC[v][15:0];
                end
            end
            // s0: readout command mid-window (R4); s1: start mid-window (R3)
            run_window(s, (s == 1) ? 100 : -1, (s == 0) ? 50 : -1, 1'b0);
        end

        // R5 empty window: header and trailer only; R3 spill not advanced by ignored start
        clear_stim();
        run_window(3, -1, -1, 1'b0);

        // R7 clear alone, then window numbered 0
        @(negedge clk);
        spill_clr = 1'b1;
        @(negedge clk);
        spill_clr = 1'b0;
        clear_stim();
        st_l[200] = 16'h0002;
        run_window(0, -1, -1, 1'b0);

        // R7 clear together with start: window 0, the next window 1
        clear_stim();
        st_e[0] = 16'hFFFF;
        run_window(0, -1, -1, 1'b1);
        clear_stim();
        for (int k = 20; k < 40; k++) begin
            st_e[k] = 16'h0100;
            st_l[k] = 16'h0100;
        end
        run_window(1, -1, -1, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule